// File: doc/BRIEF.md
# Chunked Context Swap Controller

This controller sits between a preemptible hardware core and a host processor. It moves the core's saved state, which may hold more words than the local staging buffer, out to the host and later back in. On a swap-out request it raises `swap` toward the core. The core keeps running until it reaches its next interruptible state. There it holds its context on `core_ctx` and pulses `core_ack`.

The controller then copies the context into the staging buffer one chunk at a time. It raises `irq` for each chunk and waits for the host to read the buffer and write `chunk_ack`. After the last chunk it pulses `swap_fin` and sets the sticky `fin_status`, which tells the host that the core's area can be reclaimed.

Swap-in runs in the other direction. The host writes a chunk into the buffer and acknowledges it, and the controller copies that chunk into the core's restore register. After the final chunk the controller pulses `restore_load` and drops `swap` so that the core resumes.

Top module: `swap_chunk_ctrl`

## Requirements
- R1: After reset, `swap`, `irq`, `swap_fin`, `fin_status` and `restore_load` are all low.
- R2: A `swap_out_req` accepted while idle drives `swap` high in the following cycle. No `irq` is raised until the core pulses `core_ack`.
- R3: After `core_ack`, `irq` rises with `swap` still high. Buffer address i then reads context word i, where word k is `core_ctx[k*DATA_W +: DATA_W]`.
- R4: A `chunk_ack` while `irq` is high drops `irq` in the next cycle. `irq` then rises again with chunk c in the buffer, so that address i holds word c*BUF_WORDS+i. Addresses past the end of the context read as zero.
- R5: A swap-out raises `irq` exactly ceil(CTX_WORDS/BUF_WORDS) times, and `irq` and `swap_fin` are never high together.
- R6: The `chunk_ack` for the last chunk is followed by a one-cycle `swap_fin` pulse, and `swap` stays high after it.
- R7: `fin_status` goes high with `swap_fin` and stays high until `fin_clear` is asserted.
- R8: During swap-in, each `chunk_ack` copies the buffer, which the host fills through `host_wr_en`/`host_addr`, into the restore words for the current chunk. After the final chunk, `restore_load` pulses for one cycle with all CTX_WORDS words in place, and `swap` is low in the next cycle.
- R9: A `swap_in_req` issued during a swap-out is dropped. Once `swap_fin` has been issued, further `chunk_ack` pulses neither pulse `restore_load` nor lower `swap`.
- R10: A `swap_out_req` or `core_ack` issued during a swap-in raises no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_out_req | input | 1 | Host request to save the core's context |
| swap_in_req | input | 1 | Host request to restore the core's context |
| chunk_ack | input | 1 | Host register write: chunk read (swap-out) or chunk loaded (swap-in) |
| fin_clear | input | 1 | Clears `fin_status` |
| host_wr_en | input | 1 | Host write strobe into the staging buffer (swap-in) |
| host_addr | input | $clog2(BUF_WORDS) | Buffer word address for host read or write |
| host_wr_data | input | DATA_W | Host write data |
| host_rd_data | output | DATA_W | Buffer word at `host_addr` |
| core_ack | input | 1 | Core has reached an interruptible state and holds its context |
| core_ctx | input | CTX_WORDS*DATA_W | Context presented by the core |
| swap | output | 1 | Stall/hold request to the core |
| irq | output | 1 | Chunk ready for the host to read |
| swap_fin | output | 1 | One-cycle pulse when the whole context has been read |
| fin_status | output | 1 | Sticky copy of `swap_fin` |
| restore_ctx | output | CTX_WORDS*DATA_W | Context being restored into the core |
| restore_load | output | 1 | One-cycle pulse: core loads `restore_ctx` |

## Verification
The assertions check on every cycle that `irq` only appears while `swap` is held, and that it drops after an acknowledge. They also check that `swap_fin` is a single-cycle pulse that sets the sticky status, and that `restore_load` is followed by the release of `swap`. Only the bench scenarios can show the data path and the count of chunks. These scenarios cover the word-by-word content of each chunk, the zero padding of the short final chunk, and the number of interrupts per swap-out. They also cover the reassembly of the restored context and the requests that are dropped while a transfer in the other direction is under way.

// File: rtl/swap_chunk_ctrl.sv
module swap_chunk_ctrl #(
  parameter int DATA_W    = 32,
  parameter int CTX_WORDS = 10,
  parameter int BUF_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        swap_out_req,
  input  logic                        swap_in_req,
  input  logic                        chunk_ack,
  input  logic                        fin_clear,
  input  logic                        host_wr_en,
  input  logic [$clog2(BUF_WORDS)-1:0] host_addr,
  input  logic [DATA_W-1:0]           host_wr_data,
  output logic [DATA_W-1:0]           host_rd_data,
  input  logic                        core_ack,
  input  logic [CTX_WORDS*DATA_W-1:0] core_ctx,
  output logic                        swap,
  output logic                        irq,
  output logic                        swap_fin,
  output logic                        fin_status,
  output logic [CTX_WORDS*DATA_W-1:0] restore_ctx,
  output logic                        restore_load
);
  localparam int NCHUNK = (CTX_WORDS + BUF_WORDS - 1) / BUF_WORDS;
  localparam int CW     = $clog2(NCHUNK + 1);
  localparam logic [CW-1:0] LAST = CW'(NCHUNK - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SO_WAIT, S_SO_FILL, S_SO_IRQ, S_SO_FIN, S_SI_WAIT, S_SI_COPY, S_SI_DONE
  } st_t;

  st_t             st;
  logic [CW-1:0]   chunk;
  logic [DATA_W-1:0] stage [BUF_WORDS];
  logic            swap_q, fin_q;

  assign host_rd_data = stage[host_addr];
  assign swap         = swap_q;
  assign irq          = (st == S_SO_IRQ);
  assign swap_fin     = (st == S_SO_FIN);
  assign restore_load = (st == S_SI_DONE);
  assign fin_status   = fin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      chunk  <= '0;
      swap_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      if (fin_clear) fin_q <= 1'b0;
      case (st)
        S_IDLE: begin
          chunk <= '0;
          if (swap_out_req) begin
            st <= S_SO_WAIT; swap_q <= 1'b1;
          end else if (swap_in_req) begin
            st <= S_SI_WAIT; swap_q <= 1'b1;
          end
        end
        S_SO_WAIT: if (core_ack) st <= S_SO_FILL;
        S_SO_FILL: st <= S_SO_IRQ;
        S_SO_IRQ: if (chunk_ack) begin
          chunk <= chunk + 1'b1;
          st    <= (chunk == LAST) ? S_SO_FIN : S_SO_FILL;
        end
        S_SO_FIN: begin
          fin_q <= 1'b1;
          st    <= S_IDLE;
        end
        S_SI_WAIT: if (chunk_ack) st <= S_SI_COPY;
        S_SI_COPY: begin
          chunk <= chunk + 1'b1;
          st    <= (chunk == LAST) ? S_SI_DONE : S_SI_WAIT;
        end
        S_SI_DONE: begin
          swap_q <= 1'b0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < BUF_WORDS; i++) begin
      if (st == S_SO_FILL) begin
        if (int'(chunk) * BUF_WORDS + i < CTX_WORDS)
          stage[i] <= core_ctx[(int'(chunk) * BUF_WORDS + i) * DATA_W +: DATA_W];
        else
          stage[i] <= '0;
      end else if (st == S_SI_WAIT && host_wr_en && int'(host_addr) == i) begin
        stage[i] <= host_wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) restore_ctx <= '0;
    else if (st == S_SI_COPY)
      for (int i = 0; i < BUF_WORDS; i++)
        if (int'(chunk) * BUF_WORDS + i < CTX_WORDS)
          restore_ctx[(int'(chunk) * BUF_WORDS + i) * DATA_W +: DATA_W] <= stage[i];
  end

  assert_irq_under_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> swap);
  assert_irq_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && chunk_ack) |=> !irq);
  assert_fin_not_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fin |-> !irq);
  assert_fin_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fin |=> !swap_fin);
  assert_fin_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_fin && !fin_clear) |=> fin_status);
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_load |=> !swap);
endmodule

// File: tb/swap_chunk_ctrl_tb.sv
module swap_chunk_ctrl_tb;
  localparam int W = 32, CTX = 10, BW = 4;
  localparam int NCH = (CTX + BW - 1) / BW;

  logic clk = 0, rst_n = 0;
  logic swap_out_req = 0, swap_in_req = 0, chunk_ack = 0, fin_clear = 0, host_wr_en = 0;
  logic [$clog2(BW)-1:0] host_addr = '0;
  logic [W-1:0] host_wr_data = '0, host_rd_data;
  logic core_ack = 0;
  logic [CTX*W-1:0] core_ctx, restore_ctx;
  logic swap, irq, swap_fin, fin_status, restore_load;

  int checks = 0, errors = 0, irq_count = 0;
  logic [W-1:0] expq[$];

  swap_chunk_ctrl #(.DATA_W(W), .CTX_WORDS(CTX), .BUF_WORDS(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .swap_out_req(swap_out_req), .swap_in_req(swap_in_req),
    .chunk_ack(chunk_ack), .fin_clear(fin_clear), .host_wr_en(host_wr_en),
    .host_addr(host_addr), .host_wr_data(host_wr_data), .host_rd_data(host_rd_data),
    .core_ack(core_ack), .core_ctx(core_ctx), .swap(swap), .irq(irq), .swap_fin(swap_fin),
    .fin_status(fin_status), .restore_ctx(restore_ctx), .restore_load(restore_load));

  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n && $rose(irq)) irq_count <= irq_count + 1;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 10) begin @(negedge clk); n++; end
    chk(req, {31'd0, irq}, 32'd1);
  endtask

  // monitor side of the scoreboard: pop expected word, compare with buffer read
  task automatic read_chunk(input string req);
    for (int i = 0; i < BW; i++) begin
      host_addr = i[$clog2(BW)-1:0];
      #1;
      chk(req, host_rd_data, expq.pop_front());
    end
  endtask

  initial begin
    for (int k = 0; k < CTX; k++) core_ctx[k*W +: W] = 32'hA000_0000 + k * 3 + 1;
    repeat (3) @(negedge clk);
    chk("R1 swap", {31'd0, swap}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 fin", {31'd0, swap_fin | fin_status}, 0);
    chk("R1 load", {31'd0, restore_load}, 0);
    rst_n = 1;
    @(negedge clk);

    pulse(swap_out_req);
    chk("R2 swap high", {31'd0, swap}, 1);
    repeat (3) @(negedge clk);
    chk("R2 no irq before core_ack", {31'd0, irq}, 0);
    pulse(core_ack);
    for (int c = 0; c < NCH; c++) begin
      wait_irq(c == 0 ? "R3 irq after ack" : "R4 irq next chunk");
      chk("R3 swap held", {31'd0, swap}, 1);
      for (int i = 0; i < BW; i++)  // driver side: push expected words
        expq.push_back((c*BW+i < CTX) ? 32'hA000_0000 + (c*BW+i) * 3 + 1 : 32'd0);
      read_chunk(c == NCH-1 ? "R4 last chunk padded" : "R3 chunk words");
      if (c == 0) pulse(swap_in_req);  // R9: dropped during swap-out
      @(negedge clk);
      chunk_ack = 1; @(negedge clk); chunk_ack = 0;
      if (c < NCH-1) chk("R4 irq drops", {31'd0, irq}, 0);
    end
    chk("R6 fin pulse", {31'd0, swap_fin}, 1);
    chk("R5 no irq with fin", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R6 fin one cycle", {31'd0, swap_fin}, 0);
    chk("R6 swap stays", {31'd0, swap}, 1);
    chk("R7 status set", {31'd0, fin_status}, 1);
    chk("R5 irq count", irq_count, NCH);

    // R9: stray chunk acks after fin have no restore effect
    for (int n = 0; n < 3; n++) begin
      pulse(chunk_ack);
      chk("R9 no restore_load", {31'd0, restore_load}, 0);
      @(negedge clk);
      chk("R9 no restore_load", {31'd0, restore_load}, 0);
    end
    chk("R9 swap still high", {31'd0, swap}, 1);
    chk("R7 status held", {31'd0, fin_status}, 1);
    pulse(fin_clear);
    chk("R7 status cleared", {31'd0, fin_status}, 0);

    // swap-in
    irq_count = 0;
    pulse(swap_in_req);
    pulse(swap_out_req);  // R10: ignored
    pulse(core_ack);
    repeat (3) @(negedge clk);
    chk("R10 no irq", {31'd0, irq}, 0);
    for (int k = 0; k < CTX; k++) expq.push_back(32'h5000_0000 + k * 7);
    for (int c = 0; c < NCH; c++) begin
      for (int i = 0; i < BW; i++) begin
        host_wr_en = 1; host_addr = i[$clog2(BW)-1:0];
        host_wr_data = (c*BW+i < CTX) ? 32'h5000_0000 + (c*BW+i) * 7 : 32'hDEAD_BEEF;
        @(negedge clk);
      end
      host_wr_en = 0;
      pulse(chunk_ack);
      if (c < NCH-1) begin
        chk("R8 no early load", {31'd0, restore_load}, 0);
        @(negedge clk);
      end
    end
    begin
      int n = 0;
      while (!restore_load && n < 10) begin @(negedge clk); n++; end
    end
    chk("R8 restore_load", {31'd0, restore_load}, 1);
    for (int k = 0; k < CTX; k++) chk("R8 restored word", restore_ctx[k*W +: W], expq.pop_front());
    @(negedge clk);
    chk("R8 load one cycle", {31'd0, restore_load}, 0);
    chk("R8 swap low", {31'd0, swap}, 0);
    chk("R10 no irq in swap-in", irq_count, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule